// File: doc/BRIEF.md
# Autobaud Serial Receive Front End

This block is the host-facing receive path of an embedded modem controller. After reset the host bit rate is unknown. The block measures the low time of the start bit of the first incoming character. It then snaps that measurement to the nearest standard DTE rate in a fixed twelve-entry table and locks at that rate. From then on it receives 8N1 asynchronous frames at the locked rate and delivers each byte with a one-cycle strobe. The first character, the one used for measurement, is also decoded and delivered.

Two configuration straps are captured in the first clock cycle after reset is released. Changes to them after that point have no effect until the next reset.

- The mode strap selects the host mode. High selects serial mode. Low selects parallel mode, in which this block does nothing.
- The rate strap, when low, skips measurement and fixes the rate at 19200 bps.

Bit timing uses a fractional phase accumulator that produces sixteen ticks per bit. The block requires `CLK_HZ >= 16 * 307200`.

Top module: `uart_autobaud_rx`

## Requirements
- R1: While `rst_ni` is low and right after its release, `locked_o`, `valid_o` and `frame_err_o` are 0 and `rate_idx_o` is 0.
- R2: `mode_strap_i` is sampled in the first clock after reset release. If it is sampled low (parallel mode), the block never locks and never pulses `valid_o` or `frame_err_o`. This holds whatever `rxd_i` and `rate_strap_i` do, and whatever later changes the straps make before the next reset.
- R3: If serial mode is latched and `rate_strap_i` is sampled low, `locked_o` rises within three clocks of reset release with `rate_idx_o` = 6 (19200 bps). Frames are then received at that rate without any measurement, and later changes to the strap have no effect.
- R4: In autobaud mode the first low run on the line is timed in clock cycles. The rate index encoding is 0..11 for 300, 600, 1200, 2400, 4800, 9600, 19200, 38400, 57600, 115200, 230400 and 307200 bps. If the run is within 1/8 of `CLK_HZ/rate` for entry i, `locked_o` asserts and `rate_idx_o` = i. The first character must therefore have data bit 0 = 1.
- R5: A low run that is more than 1/8 away from every entry is rejected. The block stays unlocked, delivers no byte, and waits for the next falling edge to measure again.
- R6: Once asserted, `locked_o` stays high and `rate_idx_o` stays constant until the next reset.
- R7: The character whose start bit was measured is decoded at the detected rate and delivered on `data_o` with a `valid_o` pulse.
- R8: Frames are 1 start bit, 8 data bits sent LSB first, and 1 stop bit. Each bit is the majority of three of its sixteen oversampling ticks around mid-bit. A good byte appears on `data_o` together with a one-cycle `valid_o` pulse.
- R9: A stop bit sampled low gives a one-cycle `frame_err_o` pulse. No `valid_o` pulse is produced and the byte is dropped. Reception of later frames is unaffected.
- R10: A falling edge whose line is back high at mid start bit is discarded. It produces no byte and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, frequency given by `CLK_HZ` |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Asynchronous serial receive line, idle high |
| mode_strap_i | input | 1 | Host mode strap: 1 selects serial, 0 selects parallel (block idle) |
| rate_strap_i | input | 1 | Rate strap: 0 fixes the rate at 19200 bps |
| rate_idx_o | output | 4 | Locked rate index (0 = 300 ... 11 = 307200) |
| locked_o | output | 1 | Rate chosen, sticky until reset |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-cycle strobe for a good byte |
| frame_err_o | output | 1 | One-cycle strobe for a low stop bit |

## Verification
The input passes through a two-flop synchronizer and an edge register. Because of this, lock is due about three clocks after the rising edge that ends the first start bit. A byte strobe or error strobe is due about 9/16 of a bit plus three to four clocks into the stop bit. The strap-forced lock is due two clocks after reset release.

The bench drives each frame bit by bit and then holds the line idle for two further bit times. Only after that does it compare lock state, rate index, strobe counts and the last byte. Every result has therefore had a margin of more than one bit time to settle, and no next stimulus has started that could disturb it. Pulses are counted on the falling clock edge, so each one-cycle strobe is seen exactly once.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;

  localparam int NUM_RATES = 12;
  localparam int IDX_W     = 4;
  localparam int FIXED_IDX = 6;   // 19200 bps

  function automatic int rate_bps(input int idx);
    case (idx)
      0:       return 300;
      1:       return 600;
      2:       return 1200;
      3:       return 2400;
      4:       return 4800;
      5:       return 9600;
      6:       return 19200;
      7:       return 38400;
      8:       return 57600;
      9:       return 115200;
      10:      return 230400;
      default: return 307200;
    endcase
  endfunction

  typedef enum logic [1:0] {DET_STRAP, DET_WAIT, DET_MEAS, DET_LOCK} det_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

endpackage

// File: rtl/strap_latch.sv
module strap_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_strap_i,
  input  logic rate_strap_i,
  output logic done_o,
  output logic serial_o,
  output logic fixed_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      serial_o <= 1'b0;
      fixed_o  <= 1'b0;
    end else if (!done_o) begin
      done_o   <= 1'b1;
      serial_o <= mode_strap_i;
      fixed_o  <= ~rate_strap_i;
    end
  end

  assert_strap_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ($stable(serial_o) && $stable(fixed_o) && done_o));

endmodule

// File: rtl/autobaud_detect.sv
module autobaud_detect
  import autobaud_pkg::*;
#(
  parameter int CLK_HZ = 49_152_000,
  parameter int CW     = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fixed_i,
  input  logic             fall_i,
  input  logic             rise_i,
  output logic             locked_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             go_o
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  det_state_e       st_q;
  logic [CW-1:0]    cnt_q;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;

  // nearest-rate search; tolerance windows of +-1/8 never overlap
  always_comb begin
    logic [31:0] nom, diff, cnt32;
    hit     = 1'b0;
    hit_idx = '0;
    cnt32   = 32'(cnt_q);
    for (int i = 0; i < NUM_RATES; i++) begin
      nom  = 32'(CLK_HZ / rate_bps(i));
      diff = (cnt32 > nom) ? cnt32 - nom : nom - cnt32;
      if ({diff[28:0], 3'b000} <= nom) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= DET_STRAP;
      cnt_q <= '0;
      idx_o <= '0;
      go_o  <= 1'b0;
    end else begin
      go_o <= 1'b0;
      case (st_q)
        DET_STRAP: if (en_i) begin
          if (fixed_i) begin
            st_q  <= DET_LOCK;
            idx_o <= IDX_W'(FIXED_IDX);
          end else begin
            st_q <= DET_WAIT;
          end
        end
        DET_WAIT: if (fall_i) begin
          st_q  <= DET_MEAS;
          cnt_q <= CW'(1);
        end
        DET_MEAS: begin
          if (rise_i) begin
            if (hit) begin
              st_q  <= DET_LOCK;
              idx_o <= hit_idx;
              go_o  <= 1'b1;
            end else begin
              st_q <= DET_WAIT;
            end
          end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign locked_o = (st_q == DET_LOCK);

  assert_lock_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> (locked_o && $stable(idx_o)));

  assert_go_with_lock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> (locked_o && !$past(locked_o)));

  assert_reject_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == DET_MEAS && rise_i && !hit) |=> !locked_o);

endmodule

// File: rtl/baud_tick.sv
module baud_tick #(
  parameter int CLK_HZ = 49_152_000,
  parameter int AW     = 27
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [AW-1:0] step_i,
  output logic          tick_o
);

  localparam logic [AW:0] MOD = (AW+1)'(CLK_HZ);

  logic [AW-1:0] acc_q;
  logic [AW:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, step_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (clr_i) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (sum >= MOD) begin
      acc_q  <= AW'(sum - MOD);
      tick_o <= 1'b1;
    end else begin
      acc_q  <= sum[AW-1:0];
      tick_o <= 1'b0;
    end
  end

  assert_acc_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, acc_q} < MOD));

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import autobaud_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       rxd_i,
  input  logic       fall_i,
  input  logic       go_i,
  input  logic       tick_i,
  output logic       clr_o,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       ferr_o
);

  localparam int TW = $clog2(OVS);
  localparam logic [TW-1:0] MID  = TW'(OVS / 2);
  localparam logic [TW-1:0] LAST = TW'(OVS - 1);

  rx_state_e     st_q;
  logic [TW-1:0] tcnt_q;
  logic [2:0]    bcnt_q;
  logic [1:0]    samp_q;
  logic [7:0]    shr_q;
  logic          maj;

  assign maj = (samp_q[0] & samp_q[1]) | (samp_q[0] & rxd_i) | (samp_q[1] & rxd_i);

  assign clr_o = (st_q == RX_IDLE) && (go_i || (en_i && fall_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RX_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      samp_q  <= '0;
      shr_q   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      if (st_q == RX_IDLE) begin
        tcnt_q <= '0;
        bcnt_q <= '0;
        if (go_i)                st_q <= RX_DATA;   // start bit already consumed by detector
        else if (en_i && fall_i) st_q <= RX_START;
      end else if (tick_i) begin
        tcnt_q <= tcnt_q + TW'(1);
        if (tcnt_q == MID - TW'(2)) samp_q[0] <= rxd_i;
        if (tcnt_q == MID - TW'(1)) samp_q[1] <= rxd_i;
        case (st_q)
          RX_START: begin
            if (tcnt_q == MID && maj) st_q <= RX_IDLE;
            else if (tcnt_q == LAST)  st_q <= RX_DATA;
          end
          RX_DATA: begin
            if (tcnt_q == MID) shr_q <= {maj, shr_q[7:1]};
            if (tcnt_q == LAST) begin
              if (bcnt_q == 3'd7) st_q <= RX_STOP;
              bcnt_q <= bcnt_q + 3'd1;
            end
          end
          RX_STOP: begin
            if (tcnt_q == MID) begin
              st_q <= RX_IDLE;
              if (maj) begin
                data_o  <= shr_q;
                valid_o <= 1'b1;
              end else begin
                ferr_o <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_strobe_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && ferr_o));

  assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_ferr_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_o |=> !ferr_o);

  assert_data_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));

endmodule

// File: rtl/uart_autobaud_rx.sv
module uart_autobaud_rx
  import autobaud_pkg::*;
#(
  parameter int CLK_HZ = 49_152_000,
  parameter int OVS    = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rxd_i,
  input  logic       mode_strap_i,
  input  logic       rate_strap_i,
  output logic [3:0] rate_idx_o,
  output logic       locked_o,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       frame_err_o
);

  localparam int CW = $clog2(CLK_HZ / 150 + 2);
  localparam int AW = $clog2(CLK_HZ + 1) + 1;

  logic [1:0]    sync_q;
  logic          prev_q;
  logic          rxd_s, fall, rise;
  logic          strap_done, serial_mode, fixed_rate;
  logic          go, tick, clr;
  logic [AW-1:0] step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      prev_q <= sync_q[1];
    end
  end

  assign rxd_s = sync_q[1];
  assign fall  = prev_q & ~rxd_s;
  assign rise  = ~prev_q & rxd_s;

  strap_latch i_strap (
    .clk_i,
    .rst_ni,
    .mode_strap_i,
    .rate_strap_i,
    .done_o   (strap_done),
    .serial_o (serial_mode),
    .fixed_o  (fixed_rate)
  );

  autobaud_detect #(.CLK_HZ(CLK_HZ), .CW(CW)) i_detect (
    .clk_i,
    .rst_ni,
    .en_i     (strap_done & serial_mode),
    .fixed_i  (fixed_rate),
    .fall_i   (fall),
    .rise_i   (rise),
    .locked_o (locked_o),
    .idx_o    (rate_idx_o),
    .go_o     (go)
  );

  always_comb step = AW'(OVS * rate_bps(int'(rate_idx_o)));

  baud_tick #(.CLK_HZ(CLK_HZ), .AW(AW)) i_tick (
    .clk_i,
    .rst_ni,
    .clr_i  (clr),
    .step_i (step),
    .tick_o (tick)
  );

  uart_rx_core #(.OVS(OVS)) i_rx (
    .clk_i,
    .rst_ni,
    .en_i    (locked_o),
    .rxd_i   (rxd_s),
    .fall_i  (fall),
    .go_i    (go),
    .tick_i  (tick),
    .clr_o   (clr),
    .data_o  (data_o),
    .valid_o (valid_o),
    .ferr_o  (frame_err_o)
  );

  assert_parallel_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strap_done && !serial_mode) |-> (!locked_o && !valid_o && !frame_err_o));

  assert_no_rx_unlocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o || frame_err_o) |-> locked_o);

endmodule

// File: tb/test_uart_autobaud_rx.sv
module test_uart_autobaud_rx;

  localparam int CLK_HZ = 4_915_200;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rxd = 1'b1;
  logic       mode_strap = 1'b1;
  logic       rate_strap = 1'b1;
  logic [3:0] rate_idx;
  logic       locked, valid, ferr;
  logic [7:0] data;

  int   n_chk = 0, n_bad = 0, n_valid = 0, n_ferr = 0;
  logic [7:0] last_byte = 8'h00;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  uart_autobaud_rx #(.CLK_HZ(CLK_HZ)) i_uart_autobaud_rx (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .rxd_i        (rxd),
    .mode_strap_i (mode_strap),
    .rate_strap_i (rate_strap),
    .rate_idx_o   (rate_idx),
    .locked_o     (locked),
    .data_o       (data),
    .valid_o      (valid),
    .frame_err_o  (ferr)
  );

  always @(negedge clk) begin
    if (valid) begin
      n_valid++;
      last_byte = data;
    end
    if (ferr) n_ferr++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input int bc, input bit stop_ok);
    @(negedge clk) rxd = 1'b0;
    wait_cyc(bc);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      wait_cyc(bc);
    end
    rxd = stop_ok;
    wait_cyc(bc);
    rxd = 1'b1;
    wait_cyc(2 * bc);
  endtask

  // straps flipped after capture to show they are latched
  task automatic do_reset(input bit mode, input bit rate);
    @(negedge clk);
    rst_ni = 1'b0;
    mode_strap = mode;
    rate_strap = rate;
    rxd = 1'b1;
    wait_cyc(4);
    rst_ni = 1'b1;
    wait_cyc(2);
    mode_strap = ~mode;
    rate_strap = ~rate;
    wait_cyc(4);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    mode_strap = 1'b1;
    rate_strap = 1'b1;
    wait_cyc(3);
    chk("R1 locked in reset", int'(locked), 0);
    chk("R1 valid in reset", int'(valid), 0);
    chk("R1 ferr in reset", int'(ferr), 0);
    chk("R1 rate_idx in reset", int'(rate_idx), 0);
    rst_ni = 1'b1;
    wait_cyc(5);
    chk("R1 locked after release", int'(locked), 0);
    chk("R1 rate_idx after release", int'(rate_idx), 0);
  endtask

  task automatic t_auto(input int idx, input int bc, input logic [7:0] b0, input logic [7:0] b1);
    int v0;
    do_reset(1'b1, 1'b1);
    v0 = n_valid;
    send_frame(b0, bc, 1'b1);
    chk("R4 locked", int'(locked), 1);
    chk("R4 rate_idx", int'(rate_idx), idx);
    chk("R7 first char count", n_valid, v0 + 1);
    chk("R7 first char byte", int'(last_byte), int'(b0));
    send_frame(b1, bc, 1'b1);
    chk("R8 second byte count", n_valid, v0 + 2);
    chk("R8 second byte", int'(last_byte), int'(b1));
    chk("R6 still locked", int'(locked), 1);
    chk("R6 rate_idx held", int'(rate_idx), idx);
  endtask

  task automatic t_offtable();
    int v0, f0;
    do_reset(1'b1, 1'b1);
    v0 = n_valid;
    f0 = n_ferr;
    send_frame(8'h55, 100, 1'b1);
    chk("R5 no lock off-table", int'(locked), 0);
    chk("R5 no byte off-table", n_valid, v0);
    chk("R5 no ferr off-table", n_ferr, f0);
    send_frame(8'h4B, 256, 1'b1);
    chk("R5 lock after retry", int'(locked), 1);
    chk("R5 rate_idx after retry", int'(rate_idx), 6);
    chk("R7 retry byte", int'(last_byte), 8'h4B);
  endtask

  task automatic t_fixed();
    int v0;
    do_reset(1'b1, 1'b0);
    chk("R3 forced lock", int'(locked), 1);
    chk("R3 forced rate_idx", int'(rate_idx), 6);
    v0 = n_valid;
    send_frame(8'h3C, 256, 1'b1);
    chk("R3 byte count at fixed rate", n_valid, v0 + 1);
    chk("R3 byte at fixed rate", int'(last_byte), 8'h3C);
    chk("R3 rate_idx after strap change", int'(rate_idx), 6);
  endtask

  task automatic t_glitch();
    int v0, f0;
    v0 = n_valid;
    f0 = n_ferr;
    @(negedge clk) rxd = 1'b0;
    wait_cyc(20);
    rxd = 1'b1;
    wait_cyc(3000);
    chk("R10 glitch no byte", n_valid, v0);
    chk("R10 glitch no ferr", n_ferr, f0);
    send_frame(8'h99, 256, 1'b1);
    chk("R10 byte after glitch", int'(last_byte), 8'h99);
  endtask

  task automatic t_frame_err();
    int v0, f0;
    v0 = n_valid;
    f0 = n_ferr;
    send_frame(8'h81, 256, 1'b0);
    chk("R9 ferr pulse count", n_ferr, f0 + 1);
    chk("R9 bad byte dropped", n_valid, v0);
    send_frame(8'h7E, 256, 1'b1);
    chk("R9 recovery count", n_valid, v0 + 1);
    chk("R9 recovery byte", int'(last_byte), 8'h7E);
  endtask

  task automatic t_parallel();
    int v0, f0;
    do_reset(1'b0, 1'b0);
    v0 = n_valid;
    f0 = n_ferr;
    chk("R2 parallel ignores rate strap", int'(locked), 0);
    send_frame(8'h41, 256, 1'b1);
    send_frame(8'h41, 256, 1'b0);
    chk("R2 parallel no lock", int'(locked), 0);
    chk("R2 parallel no byte", n_valid, v0);
    chk("R2 parallel no ferr", n_ferr, f0);
  endtask

  initial begin
    t_reset();
    t_auto(7, 128, 8'h41, 8'h5A);
    t_auto(11, 16, 8'h55, 8'hA3);
    t_auto(5, 512, 8'h61, 8'h00);
    t_offtable();
    t_fixed();
    t_glitch();
    t_frame_err();
    t_parallel();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule